// File: doc/BRIEF.md
# Boot Window Command Sequencer

This block watches host writes aimed at the boot area of a flash device and turns them into request pulses for the transfer logic beside it. Most commands take one write. A write of 0x00E0 arms a second cycle. The next write that lands in the boot area is taken as the confirm write. If the confirm write carries zero, the block asks for a page load and then moves its page pointer forward by four, wrapping within eight bits.

The block does not move any data. It raises a one-cycle request pulse, and the neighbouring logic does the transfer. A page-load pulse carries the page address that was current when the load was confirmed. The page pointer can also be written directly through a side port, so firmware can choose where the next load starts.

Top module: `bootcmd_seq`

## Requirements
- R1: After reset, `armed`, `load_req`, `id_req`, `reset_req` and `unk_cmd` are 0, and `page_addr` and `load_page` are 0.
- R2: Only writes to word offsets 0x0000–0x01FF or 0x8000–0x800F are commands. A write elsewhere changes no output and no state.
- R3: When not armed, a boot-area write of 0x00F0 pulses `reset_req` for one cycle in the cycle after the write. The sequencer is idle afterwards.
- R4: When not armed, a boot-area write of 0x00E0 sets `armed` from the next cycle and raises no pulse.
- R5: When armed, a boot-area write of 0x0000 pulses `load_req` for one cycle in the next cycle. At the same time, `load_page` shows the page address from before the write, `page_addr` advances by 4, and `armed` clears.
- R6: When armed, a boot-area write of any non-zero value, command codes included, only clears `armed`. It raises no pulse and leaves `page_addr` unchanged.
- R7: When not armed, a boot-area write of 0x0090 pulses `id_req` for one cycle in the next cycle. This asks for the manufacturer ID, the device ID and the low byte of the write-protect status to be placed at boot offsets 0, 1 and 2.
- R8: When not armed, a boot-area write of any other value pulses `unk_cmd` for one cycle and has no other effect.
- R9: `pa_wr_en` loads `pa_wr_data` into `page_addr` in the next cycle. It wins over a load-driven advance in the same cycle, but `load_page` still reports the old address.
- R10: The advance wraps modulo 256: a load from page 0xFC leaves `page_addr` at 0x00.
- R11: At most one of `load_req`, `id_req`, `reset_req` and `unk_cmd` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 16 | Host word offset |
| wr_data | input | 16 | Host write value |
| pa_wr_en | input | 1 | Direct page-address write strobe |
| pa_wr_data | input | 8 | Direct page-address value |
| page_addr | output | 8 | Current page pointer |
| load_page | output | 8 | Page address carried by the last load request |
| load_req | output | 1 | Page-load request pulse |
| id_req | output | 1 | ID-load request pulse |
| reset_req | output | 1 | Device reset request pulse |
| unk_cmd | output | 1 | Unknown-command pulse |
| armed | output | 1 | Second write cycle pending |

## Verification
The bench writes the edge offsets of both windows (0x01FF, 0x800F) and the offsets just past them (0x0200, 0x8010). A decoder that is off by one would arm or fire on a stray write, or miss a legal one. It also sends command codes as the confirm write. A design that re-decoded them would raise a reset or an ID pulse instead of just disarming. Finally, it confirms a load from page 0xFC, and it confirms a load in the same cycle as a direct pointer write. A wrong wrap width would leave 0x100 truncated differently. A wrong priority would show 0x04 instead of the written value, or would report the new address on `load_page`.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
   localparam logic [7:0] CODE_RESET = 8'hF0;
   localparam logic [7:0] CODE_ARM   = 8'hE0;
   localparam logic [7:0] CODE_ID    = 8'h90;

   typedef enum logic {
      ST_IDLE  = 1'b0,
      ST_ARMED = 1'b1
   } seq_state_t;

   typedef struct packed {
      logic load;
      logic id;
      logic rst;
      logic unk;
   } req_pulses_t;
endpackage

// File: rtl/bcs_window_dec.sv
module bcs_window_dec #(
   parameter int ADDR_W  = 16,
   parameter int NUM_WIN = 2,
   parameter logic [NUM_WIN-1:0][ADDR_W-1:0] WIN_LO = '0,
   parameter logic [NUM_WIN-1:0][ADDR_W-1:0] WIN_HI = '0
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   output logic              hit
);
   logic [NUM_WIN-1:0] win_hit;

   for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
      if (WIN_LO[i] > WIN_HI[i]) begin : g_bad
         $error("window bounds reversed");
      end
      assign win_hit[i] = (wr_addr >= WIN_LO[i]) && (wr_addr <= WIN_HI[i]);
   end

   assign hit = wr_en && (|win_hit);
endmodule

// File: rtl/bcs_cycle_fsm.sv
module bcs_cycle_fsm
   import bcs_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit,
   input  logic [DATA_W-1:0] wr_data,
   output logic              adv,
   output logic              armed,
   output req_pulses_t       pulses
);
   seq_state_t state_q;
   logic       is_zero;

   assign is_zero = (wr_data == '0);
   assign adv     = hit && (state_q == ST_ARMED) && is_zero;
   assign armed   = (state_q == ST_ARMED);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pulses  <= '0;
      end else begin
         pulses <= '0;
         if (hit) begin
            if (state_q == ST_ARMED) begin
               state_q    <= ST_IDLE;
               pulses.load <= is_zero;
            end else if (wr_data == DATA_W'(CODE_RESET)) begin
               state_q   <= ST_IDLE;
               pulses.rst <= 1'b1;
            end else if (wr_data == DATA_W'(CODE_ARM)) begin
               state_q <= ST_ARMED;
            end else if (wr_data == DATA_W'(CODE_ID)) begin
               pulses.id <= 1'b1;
            end else begin
               pulses.unk <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/bcs_page_reg.sv
module bcs_page_reg #(
   parameter int PAGE_W    = 8,
   parameter int PAGE_STEP = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic              pa_wr_en,
   input  logic [PAGE_W-1:0] pa_wr_data,
   output logic [PAGE_W-1:0] page_q,
   output logic [PAGE_W-1:0] load_page_q
);
   localparam logic [PAGE_W-1:0] STEP = PAGE_W'(PAGE_STEP);

   logic [PAGE_W-1:0] page_inc;

   if ((PAGE_STEP & (PAGE_STEP - 1)) == 0) begin : g_pow2
      assign page_inc = {page_q[PAGE_W-1:$clog2(PAGE_STEP)] + 1'b1,
                         page_q[$clog2(PAGE_STEP)-1:0]};
   end else begin : g_add
      assign page_inc = page_q + STEP;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         page_q      <= '0;
         load_page_q <= '0;
      end else begin
         if (adv) load_page_q <= page_q;
         if (pa_wr_en)  page_q <= pa_wr_data;
         else if (adv)  page_q <= page_inc;
      end
   end
endmodule

// File: rtl/bootcmd_seq.sv
module bootcmd_seq
   import bcs_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 16,
   parameter int PAGE_W    = 8,
   parameter int PAGE_STEP = 4,
   parameter int NUM_WIN   = 2,
   parameter logic [NUM_WIN-1:0][ADDR_W-1:0] WIN_LO = {16'h8000, 16'h0000},
   parameter logic [NUM_WIN-1:0][ADDR_W-1:0] WIN_HI = {16'h800F, 16'h01FF}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              pa_wr_en,
   input  logic [PAGE_W-1:0] pa_wr_data,
   output logic [PAGE_W-1:0] page_addr,
   output logic [PAGE_W-1:0] load_page,
   output logic              load_req,
   output logic              id_req,
   output logic              reset_req,
   output logic              unk_cmd,
   output logic              armed
);
   if (DATA_W < 8)                 begin : g_chk_dw   $error("DATA_W too small"); end
   if (PAGE_STEP < 2)              begin : g_chk_st   $error("PAGE_STEP too small"); end
   if (PAGE_STEP >= (1 << PAGE_W)) begin : g_chk_pw   $error("PAGE_STEP too large"); end

   logic        hit, adv;
   req_pulses_t pulses;

   bcs_window_dec #(.ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI))
   u_dec (.wr_en(wr_en), .wr_addr(wr_addr), .hit(hit));

   bcs_cycle_fsm #(.DATA_W(DATA_W))
   u_fsm (.clk(clk), .rst_n(rst_n), .hit(hit), .wr_data(wr_data),
          .adv(adv), .armed(armed), .pulses(pulses));

   bcs_page_reg #(.PAGE_W(PAGE_W), .PAGE_STEP(PAGE_STEP))
   u_page (.clk(clk), .rst_n(rst_n), .adv(adv), .pa_wr_en(pa_wr_en),
           .pa_wr_data(pa_wr_data), .page_q(page_addr), .load_page_q(load_page));

   assign load_req  = pulses.load;
   assign id_req    = pulses.id;
   assign reset_req = pulses.rst;
   assign unk_cmd   = pulses.unk;
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
   parameter int PAGE_W    = 8,
   parameter int PAGE_STEP = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pa_wr_en,
   input logic [PAGE_W-1:0] pa_wr_data,
   input logic [PAGE_W-1:0] page_addr,
   input logic [PAGE_W-1:0] load_page,
   input logic              load_req,
   input logic              id_req,
   input logic              reset_req,
   input logic              unk_cmd,
   input logic              armed
);
   p_one_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({load_req, id_req, reset_req, unk_cmd}));

   p_load_needs_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
      load_req |-> $past(armed) && !armed);

   p_load_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (load_req && !$past(pa_wr_en)) |-> page_addr == PAGE_W'(load_page + PAGE_W'(PAGE_STEP)));

   p_direct_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(pa_wr_en) |-> page_addr == $past(pa_wr_data));

   p_reset_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |-> !armed);

   p_arm_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed) |-> !(load_req || id_req || reset_req || unk_cmd));
endmodule

bind bootcmd_seq bcs_checker #(.PAGE_W(PAGE_W), .PAGE_STEP(PAGE_STEP)) u_chk (
   .clk(clk), .rst_n(rst_n), .pa_wr_en(pa_wr_en), .pa_wr_data(pa_wr_data),
   .page_addr(page_addr), .load_page(load_page), .load_req(load_req),
   .id_req(id_req), .reset_req(reset_req), .unk_cmd(unk_cmd), .armed(armed));

// File: tb/sim_bootcmd_seq.sv
module sim_bootcmd_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        pa_wr_en = 1'b0;
   logic [7:0]  pa_wr_data = '0;
   logic [7:0]  page_addr, load_page;
   logic        load_req, id_req, reset_req, unk_cmd, armed;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   bit done = 0;

   int m_armed, m_page, m_lpage, m_load, m_id, m_rst, m_unk;

   always #10 clk = ~clk;

   bootcmd_seq u0 (.*);

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   // reference model, updated on each rising edge from the driven inputs
   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_armed = 0; m_page = 0; m_lpage = 0;
         m_load = 0; m_id = 0; m_rst = 0; m_unk = 0;
      end else begin
         bit in_win, adv;
         in_win = wr_en && (wr_addr <= 16'h01FF || (wr_addr >= 16'h8000 && wr_addr <= 16'h800F));
         adv = 0;
         m_load = 0; m_id = 0; m_rst = 0; m_unk = 0;
         if (in_win) begin
            if (m_armed != 0) begin
               m_armed = 0;
               if (wr_data == 16'h0000) begin
                  adv = 1; m_load = 1; m_lpage = m_page;
               end
            end else if (wr_data == 16'h00F0) m_rst = 1;
            else if (wr_data == 16'h00E0) m_armed = 1;
            else if (wr_data == 16'h0090) m_id = 1;
            else m_unk = 1;
         end
         if (pa_wr_en) m_page = pa_wr_data;
         else if (adv) m_page = (m_page + 4) % 256;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R3 reset_req", reset_req, m_rst);
         chk("R4 armed", armed, m_armed);
         chk("R5 load_req", load_req, m_load);
         chk("R5 load_page", load_page, m_lpage);
         chk("R7 id_req", id_req, m_id);
         chk("R8 unk_cmd", unk_cmd, m_unk);
         chk("R9 page_addr", page_addr, m_page);
         chk("R11 pulse count", $countones({load_req, id_req, reset_req, unk_cmd}) <= 1, 1);
      end
   end

   always @(posedge clk) begin
      if (cyc > 150000 && !done) begin
         done = 1;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   task automatic wr(input logic [15:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 armed", armed, 0);
      chk("R1 pulses", {load_req, id_req, reset_req, unk_cmd}, 0);
      chk("R1 page_addr", page_addr, 0);
      chk("R1 load_page", load_page, 0);

      wr(16'h0000, 16'h00F0); chk("R3 reset pulse", reset_req, 1);
      wr(16'h0005, 16'h0090); chk("R7 id pulse", id_req, 1);
      wr(16'h0100, 16'h1234); chk("R8 unknown pulse", unk_cmd, 1);
      wr(16'h8000, 16'h00E0); chk("R4 arm", armed, 1);
      wr(16'h0200, 16'h0000); chk("R2 outside low window keeps arm", armed, 1);
      chk("R2 outside no load", load_req, 0);
      wr(16'h800F, 16'h0000); chk("R5 load", load_req, 1);
      chk("R5 page advance", page_addr, 8'h04);
      chk("R5 load page", load_page, 8'h00);
      wr(16'h01FF, 16'h00E0);
      wr(16'h0000, 16'h00F0); chk("R6 confirm code no reset", reset_req, 0);
      chk("R6 disarmed", armed, 0);
      chk("R6 page unchanged", page_addr, 8'h04);
      wr(16'h8010, 16'h00F0); chk("R2 outside high window no reset", reset_req, 0);
      chk("R2 outside high window no unk", unk_cmd, 0);

      @(negedge clk); pa_wr_en = 1'b1; pa_wr_data = 8'hFC;
      @(negedge clk); pa_wr_en = 1'b0;
      chk("R9 direct write", page_addr, 8'hFC);
      wr(16'h0010, 16'h00E0);
      wr(16'h0010, 16'h0000); chk("R10 wrap", page_addr, 8'h00);
      chk("R10 load page", load_page, 8'hFC);

      wr(16'h8001, 16'h00E0);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 16'h8002; wr_data = 16'h0000;
      pa_wr_en = 1'b1; pa_wr_data = 8'h40;
      @(negedge clk);
      wr_en = 1'b0; pa_wr_en = 1'b0;
      chk("R9 priority page", page_addr, 8'h40);
      chk("R9 priority load_page", load_page, 8'h00);
      chk("R9 priority load", load_req, 1);

      for (int i = 0; i < 3000; i++) begin
         int sel;
         @(negedge clk);
         sel = $urandom_range(0, 9);
         wr_en = ($urandom_range(0, 3) != 0);
         case ($urandom_range(0, 5))
            0: wr_addr = 16'($urandom_range(0, 16'h01FF));
            1: wr_addr = 16'h8000 + 16'($urandom_range(0, 15));
            2: wr_addr = 16'h0200;
            3: wr_addr = 16'h8010;
            4: wr_addr = 16'h01FF;
            default: wr_addr = 16'($urandom);
         endcase
         case (sel)
            0, 1: wr_data = 16'h0000;
            2, 3: wr_data = 16'h00E0;
            4: wr_data = 16'h00F0;
            5: wr_data = 16'h0090;
            default: wr_data = 16'($urandom);
         endcase
         pa_wr_en = ($urandom_range(0, 15) == 0);
         pa_wr_data = 8'($urandom);
      end
      @(negedge clk);
      wr_en = 1'b0; pa_wr_en = 1'b0;
      @(negedge clk);
      @(negedge clk);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule